// File: doc/BRIEF.md
# Drift-Corrected Nanosecond Time Counter

This block keeps the free-running 64-bit nanosecond time of a network timestamp unit. Every core cycle that the counter is not paused, the time moves forward by one tick of 16 ns. A small register port lets software pause the count, load a new 64-bit value in two 32-bit halves while paused, and resume. Software reads the live time as a low half followed by a high half. Reading the low half captures the high half, so the pair that comes back is always consistent.

Frequency trimming uses a periodic step correction rather than a fractional accumulator. Software packs one 32-bit trim word. It holds a period counted in ticks, a step size of 0 to 7 ns, and a sign. A tick counter starts at zero and counts up to the programmed period. On the tick where it matches the period, the time advances by 16 ns plus or minus the step size, and the tick counter restarts from zero. The trim word can only be replaced while the trim logic is held in reset through its own hold register, which reads back its state.

Top module: `ptp_time_core`

## Requirements
- R1: After reset the time is zero, the counter is running, the trim hold is clear, the trim word is zero, and the status register (address 7) reads 0.
- R2: While running, with no trim step due, the time advances by exactly 16 on every clock cycle.
- R3: Writing 2 to the control register (address 0) pauses the counter from the next cycle onward, and the time then stays constant. Writing 4 resumes counting. Status bit 0 is 1 while paused.
- R4: While paused, a write to address 1 replaces time bits 31:0 and a write to address 2 replaces time bits 63:32.
- R5: While running, writes to addresses 1 and 2 have no effect on the time.
- R6: Writing bit 0 of address 3 sets or clears the trim hold, and reading address 3 returns the hold in bit 0. A write of the trim word (address 4) is taken only while the hold is 1; otherwise it is ignored. Reading address 4 returns the stored word.
- R7: Trim word layout: bits 27:0 hold the period P, bits 30:28 the step size A, and bit 31 the sign (0 = add, 1 = subtract). With the hold clear, each counting cycle where the tick counter equals P advances the time by 16+A or 16−A, and the tick counter then restarts at 0. Over N counting cycles from release, the time moves by 16·N ± A·floor(N/(P+1)).
- R8: A step size of 0, or a hold of 1, gives no correction: the time moves by exactly 16 per counting cycle.
- R9: The largest period, 0xFFFFFFF, is accepted and produces no correction within any run shorter than that many ticks.
- R10: A read of address 5 returns time bits 31:0 and captures bits 63:32. A later read of address 6 returns the captured half, even if the live high half has changed in between. Read data appears on the cycle after the read strobe.
- R11: Control writes of any value other than 2 or 4 leave the paused state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| time_ns | output | 64 | Live time in nanoseconds |
| status | output | 3 | Bit 0 paused, bit 1 trim hold, bit 2 trim active |

## Verification
The hardest situation to reach is a trim step that falls exactly on a known cycle. To be predictable, the tick counter has to start from a known phase. The stimulus therefore pauses the counter, zeroes the time, raises the hold, writes the trim word, and drops the hold, all while paused. It then resumes and pauses again after an exact number of cycles. The accumulated time then depends only on the period, the step and the cycle count. The snapshot case is reached by loading a low half just below wrap-around. The bench reads the low half, lets the carry reach the high half, and then reads the high half.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

    localparam int unsigned PERIOD_W = 28;
    localparam int unsigned STEP_W   = 3;

    typedef enum logic [2:0] {
        RA_CTRL    = 3'd0,
        RA_LOAD_LO = 3'd1,
        RA_LOAD_HI = 3'd2,
        RA_HOLD    = 3'd3,
        RA_TRIM    = 3'd4,
        RA_TIME_LO = 3'd5,
        RA_TIME_HI = 3'd6,
        RA_STATUS  = 3'd7
    } reg_addr_e;

    localparam logic [31:0] CMD_PAUSE  = 32'd2;
    localparam logic [31:0] CMD_RESUME = 32'd4;

    typedef struct packed {
        logic                neg;
        logic [STEP_W-1:0]   step;
        logic [PERIOD_W-1:0] period;
    } trim_word_t;

endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
    import ptp_tc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TIME_W-1:0] time_i,
    input  logic              trim_active_i,
    output logic              paused_o,
    output logic              hold_o,
    output trim_word_t        trim_o,
    output logic [1:0]        load_en_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic              paused;
        logic              hold;
        trim_word_t        trim;
        logic [DATA_W-1:0] snap_hi;
        logic [DATA_W-1:0] rdata;
    } regs_st_t;

    regs_st_t st_d, st_q;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        unique case (reg_addr_e'(addr))
            RA_CTRL:    rd_mux = DATA_W'(st_q.paused);
            RA_HOLD:    rd_mux = DATA_W'(st_q.hold);
            RA_TRIM:    rd_mux = DATA_W'(st_q.trim);
            RA_TIME_LO: rd_mux = time_i[DATA_W-1:0];
            RA_TIME_HI: rd_mux = st_q.snap_hi;
            RA_STATUS:  rd_mux = DATA_W'({trim_active_i, st_q.hold, st_q.paused});
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (reg_addr_e'(addr))
                RA_CTRL: begin
                    if (wdata == DATA_W'(CMD_PAUSE))  st_d.paused = 1'b1;
                    if (wdata == DATA_W'(CMD_RESUME)) st_d.paused = 1'b0;
                end
                RA_HOLD: st_d.hold = wdata[0];
                RA_TRIM: if (st_q.hold) st_d.trim = trim_word_t'(wdata[31:0]);
                default: ;
            endcase
        end
        if (rd_en) begin
            st_d.rdata = rd_mux;
            if (reg_addr_e'(addr) == RA_TIME_LO) st_d.snap_hi = time_i[TIME_W-1:DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign paused_o     = st_q.paused;
    assign hold_o       = st_q.hold;
    assign trim_o       = st_q.trim;
    assign load_en_o[0] = wr_en && st_q.paused && (reg_addr_e'(addr) == RA_LOAD_LO);
    assign load_en_o[1] = wr_en && st_q.paused && (reg_addr_e'(addr) == RA_LOAD_HI);
    assign rdata_o      = st_q.rdata;

endmodule

// File: rtl/ptp_tc_drift.sv
module ptp_tc_drift
    import ptp_tc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              advance_i,
    input  trim_word_t        trim_i,
    output logic              active_o,
    output logic              corr_en_o,
    output logic              corr_neg_o,
    output logic [STEP_W-1:0] corr_step_o
);

    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
    } drift_st_t;

    drift_st_t st_d, st_q;
    logic      at_period;

    assign at_period = (st_q.cnt == trim_i.period);

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.cnt = '0;
        end else if (advance_i) begin
            st_d.cnt = at_period ? '0 : st_q.cnt + PERIOD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o    = !hold_i && (trim_i.step != '0);
    assign corr_en_o   = active_o && advance_i && at_period;
    assign corr_neg_o  = trim_i.neg;
    assign corr_step_o = trim_i.step;

endmodule

// File: rtl/ptp_tc_clock.sv
module ptp_tc_clock #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned TIME_W  = 64,
    parameter int unsigned TICK_NS = 16,
    parameter int unsigned STEP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance_i,
    input  logic              corr_en_i,
    input  logic              corr_neg_i,
    input  logic [STEP_W-1:0] corr_step_i,
    input  logic [1:0]        load_en_i,
    input  logic [DATA_W-1:0] load_data_i,
    output logic [TIME_W-1:0] time_o
);

    localparam int unsigned NSEG = TIME_W / DATA_W;

    typedef struct packed {
        logic [TIME_W-1:0] t;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic [TIME_W-1:0]                stepped;
    logic [NSEG-1:0][DATA_W-1:0]      seg_next;

    always_comb begin
        stepped = st_q.t + TIME_W'(TICK_NS);
        if (corr_en_i) begin
            if (corr_neg_i) stepped = stepped - TIME_W'(corr_step_i);
            else            stepped = stepped + TIME_W'(corr_step_i);
        end
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign seg_next[g] = load_en_i[g] ? load_data_i :
                             advance_i    ? stepped[g*DATA_W +: DATA_W] :
                                            st_q.t[g*DATA_W +: DATA_W];
    end

    always_comb begin
        st_d   = st_q;
        st_d.t = seg_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign time_o = st_q.t;

endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
    import ptp_tc_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned TIME_W  = 64,
    parameter int unsigned TICK_NS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [TIME_W-1:0] time_ns,
    output logic [2:0]        status
);

    logic              paused_w;
    logic              hold_w;
    trim_word_t        trim_w;
    logic [1:0]        load_en_w;
    logic              active_w;
    logic              corr_en_w;
    logic              corr_neg_w;
    logic [STEP_W-1:0] corr_step_w;

    ptp_tc_regs #(.DATA_W(DATA_W), .TIME_W(TIME_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .addr          (addr),
        .wdata         (wdata),
        .time_i        (time_ns),
        .trim_active_i (active_w),
        .paused_o      (paused_w),
        .hold_o        (hold_w),
        .trim_o        (trim_w),
        .load_en_o     (load_en_w),
        .rdata_o       (rdata)
    );

    ptp_tc_drift u_drift (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (hold_w),
        .advance_i   (!paused_w),
        .trim_i      (trim_w),
        .active_o    (active_w),
        .corr_en_o   (corr_en_w),
        .corr_neg_o  (corr_neg_w),
        .corr_step_o (corr_step_w)
    );

    ptp_tc_clock #(.DATA_W(DATA_W), .TIME_W(TIME_W), .TICK_NS(TICK_NS), .STEP_W(STEP_W)) u_clock (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance_i   (!paused_w),
        .corr_en_i   (corr_en_w),
        .corr_neg_i  (corr_neg_w),
        .corr_step_i (corr_step_w),
        .load_en_i   (load_en_w),
        .load_data_i (wdata),
        .time_o      (time_ns)
    );

    assign status = {active_w, hold_w, paused_w};

endmodule

// File: rtl/ptp_time_core_chk.sv
module ptp_time_core_chk #(
    parameter int unsigned TIME_W  = 64,
    parameter int unsigned TICK_NS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [31:0]       wdata,
    input logic [TIME_W-1:0] time_ns,
    input logic              paused,
    input logic              hold,
    input logic [31:0]       trim
);

    logic load_wr;
    assign load_wr = wr_en && (addr == 3'd1 || addr == 3'd2);

    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !load_wr) |=> $stable(time_ns)); // R3

    AST_PAUSE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && wdata == 32'd2) |=> paused); // R3

    AST_RESUME_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && wdata == 32'd4) |=> !paused); // R3

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !paused |=> ((time_ns - $past(time_ns)) >= TIME_W'(TICK_NS - 7)
                  && (time_ns - $past(time_ns)) <= TIME_W'(TICK_NS + 7))); // R7

    AST_HOLD_NO_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
        (!paused && hold) |=> (time_ns == $past(time_ns) + TIME_W'(TICK_NS))); // R8

    AST_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!paused && trim[30:28] == 3'd0) |=> (time_ns == $past(time_ns) + TIME_W'(TICK_NS))); // R8

    AST_TRIM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> $stable(trim)); // R6

    AST_CTRL_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && wdata != 32'd2 && wdata != 32'd4) |=> $stable(paused)); // R11

endmodule

bind ptp_time_core ptp_time_core_chk #(.TIME_W(TIME_W), .TICK_NS(TICK_NS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .time_ns (time_ns),
    .paused  (paused_w),
    .hold    (hold_w),
    .trim    (32'(trim_w))
);

// File: tb/ptp_time_core_test.sv
module ptp_time_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] time_ns;
    logic [2:0]  status;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ptp_time_core uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .time_ns(time_ns), .status(status)
    );

    // {trim word, counting cycles}
    localparam logic [63:0] VEC [7] = '{
        {32'h0000_0000, 32'd50},   // R8 trim off
        {32'h5000_0003, 32'd40},   // R7 add 5 every 4
        {32'hF000_0000, 32'd10},   // R7 subtract 7 every tick
        {32'h1000_0009, 32'd25},   // R7 add 1 every 10
        {32'hB000_0004, 32'd30},   // R7 subtract 3 every 5
        {32'h8000_0002, 32'd20},   // R8 zero step, sign set
        {32'h7FFF_FFFF, 32'd100}   // R9 largest period
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, hi;
        logic [63:0] t0;
        repeat (3) @(negedge clk);
        check("R1 time in reset", time_ns, 64'd0);
        rst_n = 1'b1;
        rd(3'd7, v);
        check("R1 status", {32'd0, v}, 64'd0);
        rd(3'd4, v);
        check("R1 trim word", {32'd0, v}, 64'd0);

        // R2 running step
        t0 = time_ns;
        @(negedge clk);
        check("R2 step 16", time_ns, t0 + 64'd16);

        // R5 load while running ignored
        t0 = time_ns;
        wr(3'd1, 32'h0000_0123);
        check("R5 load ignored", time_ns, t0 + 64'd16);

        // R11 unknown control value
        wr(3'd0, 32'd3);
        rd(3'd7, v);
        check("R11 still running", {63'd0, v[0]}, 64'd0);

        // R3 pause
        wr(3'd0, 32'd2);
        t0 = time_ns;
        repeat (10) @(negedge clk);
        check("R3 frozen", time_ns, t0);
        rd(3'd0, v);
        check("R3 paused bit", {32'd0, v}, 64'd1);

        // R4 load while paused
        wr(3'd1, 32'hDEAD_BEEF);
        wr(3'd2, 32'h0000_00A5);
        check("R4 loaded", time_ns, 64'h0000_00A5_DEAD_BEEF);

        // R6 trim write ignored without hold
        wr(3'd4, 32'h3000_0007);
        rd(3'd4, v);
        check("R6 trim ignored", {32'd0, v}, 64'd0);
        wr(3'd3, 32'd1);
        rd(3'd3, v);
        check("R6 hold readback", {32'd0, v}, 64'd1);
        wr(3'd4, 32'h3000_0007);
        rd(3'd4, v);
        check("R6 trim taken", {32'd0, v}, 64'h3000_0007);
        wr(3'd3, 32'd0);

        // table walk
        foreach (VEC[i]) begin
            logic [31:0] tw, n, lo;
            logic [63:0] k, expv;
            tw = VEC[i][63:32];
            n  = VEC[i][31:0];
            wr(3'd0, 32'd2);
            wr(3'd1, 32'd0);
            wr(3'd2, 32'd0);
            wr(3'd3, 32'd1);
            wr(3'd4, tw);
            wr(3'd3, 32'd0);
            wr(3'd0, 32'd4);
            repeat (n - 1) @(negedge clk);
            wr(3'd0, 32'd2);
            rd(3'd5, lo);
            rd(3'd6, hi);
            k = 64'(n) / (64'(tw[27:0]) + 64'd1);
            expv = 64'd16 * 64'(n);
            if (tw[31]) expv = expv - 64'(tw[30:28]) * k;
            else        expv = expv + 64'(tw[30:28]) * k;
            check(tw[30:28] == 3'd0 ? "R8 no trim" :
                  tw[27:0] == 28'hFFFFFFF ? "R9 max period" : "R7 trim total",
                  {hi, lo}, expv);
        end

        // R10 snapshot coherence across a carry
        wr(3'd3, 32'd1);
        wr(3'd4, 32'd0);
        wr(3'd3, 32'd0);
        wr(3'd1, 32'hFFFF_FF00);
        wr(3'd2, 32'd7);
        wr(3'd0, 32'd4);
        rd(3'd5, v);
        check("R10 low half", {32'd0, v}, 64'h0000_0000_FFFF_FF00);
        repeat (20) @(negedge clk);
        rd(3'd6, hi);
        check("R10 captured high", {32'd0, hi}, 64'd7);
        check("R10 live high moved", {32'd0, time_ns[63:32]}, 64'd8);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule